// File: doc/BRIEF.md
# Sixteen-Bit Subset Single-Cycle Core

This block is a minimal single-cycle processor for a reduced set of 16-bit compressed load/store instructions. In every clock cycle it presents the program counter on the instruction port and takes back one halfword. In the same cycle it decodes that halfword, reads its operands from eight 32-bit registers, works out the result, the memory address and the next program counter, and then commits all state on the rising clock edge. The data memory is seen as one word-wide port. Reads through it are combinational, and a write is taken on the clock edge while the write strobe is high.

The decoded set has five parts. Word loads and stores use a base register and a scaled 5-bit offset. Additions and subtractions take a register or a 3-bit immediate. A two-operand logic and shift group uses the destination register as its first source. Conditional branches test a single flag, and one unconditional branch completes the set. Every other halfword, including 0xBF00 and the all-zero halfword, executes as a no-operation. Only registers 0 to 7 exist, and every register field is three bits wide.

Top module: `m16_core`

## Requirements
- R1: A synchronous active-high reset sets the PC, all eight registers and the N, Z, C and V flags to zero.
- R2: The fetch address equals the PC. After any instruction that is not a taken branch, the PC advances by 2.
- R3: Pattern 0110 in bits [15:12] is a word access. The address is R[bits 5:3] + (bits 10:6) × 4. When bit 11 is 1, a load writes the addressed word into R[bits 2:0] and leaves the flags unchanged. When bit 11 is 0, a store raises the write strobe for exactly that cycle with data R[bits 2:0] and changes no register and no flag. The strobe is low for every other instruction.
- R4: Pattern 00011 in bits [15:11] is an add or a subtract. Bit 9 selects subtract, and bit 10 selects a zero-extended immediate in bits [8:6] in place of R[bits 8:6]. The first operand is R[bits 5:3]. The result goes to R[bits 2:0] and sets N, Z, C and V. After a subtract, C is 1 when no borrow occurs.
- R5: Pattern 010000 in bits [15:10] is a two-operand operation on Rd = bits [2:0] and Rs = bits [5:3], with the result written into Rd. The op field is bits [9:6]: 0000 gives Rd AND Rs, 0001 gives Rd XOR Rs, 1100 gives Rd OR Rs, 1110 gives Rd AND NOT Rs, and 1111 gives NOT Rs. These five operations set N and Z and keep C and V.
- R6: In the same group, op 0010 is a left shift, 0011 a logical right shift, 0100 an arithmetic right shift and 0111 a right rotate of Rd. The shift amount is Rs[7:0]. C takes the last bit shifted out. An amount of 0 keeps C and Rd. Logical shifts by 32 give 0, with C set to the last bit shifted out. Beyond 32 they give 0 with C = 0. Arithmetic shifts of 32 or more fill the result with the sign bit and set C to the sign bit. A rotate uses the amount modulo 32, and C takes result bit 31. V is kept.
- R7: The halfwords 0xBF00 and 0x0000, the unlisted ops of the two-operand group, and every other undecoded pattern change no register, no flag and no memory.
- R8: Pattern 1101 in bits [15:12] is a conditional branch on bits [11:8]. The conditions are: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear. Codes 8 to 15 are never taken. When the branch is taken, the PC becomes PC + 4 + sign-extended (bits 7:0 × 2).
- R9: Pattern 11100 in bits [15:11] always branches, to PC + 4 + sign-extended (bits 10:0 × 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 32 | Byte address of the halfword to execute (the PC) |
| imemData | input | 16 | Instruction halfword at imemAddr |
| dmemAddr | output | 32 | Byte address of the data word for a load or store |
| dmemWdata | output | 32 | Word to store |
| dmemWe | output | 1 | Store strobe, taken on the rising edge |
| dmemRdata | input | 32 | Word read combinationally at dmemAddr |

## Verification
The fetch address, the store strobe, the store address and data, and the load address all belong to the instruction currently fetched, so they are due in the same cycle as that instruction. The bench samples them on the falling edge, before the edge that commits that instruction. A register or flag result commits on the next rising edge and shows up only through a later instruction. It is checked when a store reads that register or uses it as a base, and when a branch tests a flag. A failing store-data check therefore names the requirement of the instruction that last wrote the register. A reference model steps once per falling edge, and at the end of the run the whole data memory is compared with the model's copy.

// File: rtl/m16_pkg.sv
package m16_pkg;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_EOR, ALU_ORR, ALU_BIC, ALU_MVN,
    ALU_LSL, ALU_LSR, ALU_ASR, ALU_ROR
  } aluOp_e;

  typedef enum logic [1:0] {
    SRCB_RM, SRCB_IMM3, SRCB_RN, SRCB_OFF5
  } srcB_e;

  typedef enum logic [1:0] {
    NPC_SEQ, NPC_COND, NPC_JUMP
  } npc_e;

  typedef struct packed {
    logic   regWrite;
    logic   memWrite;
    logic   memToReg;
    logic   setNZ;
    logic   setCV;
    logic   setShiftC;
    logic   aFromRd;
    aluOp_e aluOp;
    srcB_e  srcB;
    npc_e   npcSel;
  } ctrl_t;

endpackage

// File: rtl/m16_control.sv
module m16_control
  import m16_pkg::*;
(
  input  logic [15:6] insnHi,
  output ctrl_t       ctrl
);

  logic isMem, isArith, isDp, isCond, isJump;

  assign isMem   = (insnHi[15:12] == 4'b0110);
  assign isArith = (insnHi[15:11] == 5'b00011);
  assign isDp    = (insnHi[15:10] == 6'b010000);
  assign isCond  = (insnHi[15:12] == 4'b1101);
  assign isJump  = (insnHi[15:11] == 5'b11100);

  always_comb begin
    ctrl.regWrite  = 1'b0;
    ctrl.memWrite  = 1'b0;
    ctrl.memToReg  = 1'b0;
    ctrl.setNZ     = 1'b0;
    ctrl.setCV     = 1'b0;
    ctrl.setShiftC = 1'b0;
    ctrl.aFromRd   = 1'b0;
    ctrl.aluOp     = ALU_ADD;
    ctrl.srcB      = SRCB_RM;
    ctrl.npcSel    = NPC_SEQ;
    if (isMem) begin
      ctrl.srcB = SRCB_OFF5;
      if (insnHi[11]) begin
        ctrl.regWrite = 1'b1;
        ctrl.memToReg = 1'b1;
      end else begin
        ctrl.memWrite = 1'b1;
      end
    end else if (isArith) begin
      ctrl.regWrite = 1'b1;
      ctrl.setNZ    = 1'b1;
      ctrl.setCV    = 1'b1;
      ctrl.aluOp    = insnHi[9] ? ALU_SUB : ALU_ADD;
      ctrl.srcB     = insnHi[10] ? SRCB_IMM3 : SRCB_RM;
    end else if (isDp) begin
      ctrl.aFromRd  = 1'b1;
      ctrl.srcB     = SRCB_RN;
      ctrl.regWrite = 1'b1;
      ctrl.setNZ    = 1'b1;
      case (insnHi[9:6])
        4'b0000: ctrl.aluOp = ALU_AND;
        4'b0001: ctrl.aluOp = ALU_EOR;
        4'b1100: ctrl.aluOp = ALU_ORR;
        4'b1110: ctrl.aluOp = ALU_BIC;
        4'b1111: ctrl.aluOp = ALU_MVN;
        4'b0010: begin ctrl.aluOp = ALU_LSL; ctrl.setShiftC = 1'b1; end
        4'b0011: begin ctrl.aluOp = ALU_LSR; ctrl.setShiftC = 1'b1; end
        4'b0100: begin ctrl.aluOp = ALU_ASR; ctrl.setShiftC = 1'b1; end
        4'b0111: begin ctrl.aluOp = ALU_ROR; ctrl.setShiftC = 1'b1; end
        default: begin
          ctrl.regWrite = 1'b0;
          ctrl.setNZ    = 1'b0;
        end
      endcase
    end else if (isCond) begin
      ctrl.npcSel = NPC_COND;
    end else if (isJump) begin
      ctrl.npcSel = NPC_JUMP;
    end
  end

endmodule

// File: rtl/m16_alu.sv
module m16_alu
  import m16_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  aluOp_e        op,
  output logic [DW-1:0] result,
  output logic          carry,
  output logic          overflow,
  output logic          shiftCValid
);

  localparam int SHW = $clog2(DW);

  logic [7:0]      amt;
  logic            isSub;
  logic [DW-1:0]   bEff;
  logic [DW:0]     sum;
  logic [2*DW-1:0] lslWide, lsrWide, asrWide, rorWide;
  logic [SHW-1:0]  rot;

  assign amt   = opB[7:0];
  assign rot   = amt[SHW-1:0];
  assign isSub = (op == ALU_SUB);
  assign bEff  = isSub ? ~opB : opB;
  assign sum   = {1'b0, opA} + {1'b0, bEff} + {{DW{1'b0}}, isSub};

  assign lslWide = {{DW{1'b0}}, opA} << amt;
  assign lsrWide = {opA, {DW{1'b0}}} >> amt;
  assign asrWide = $signed({opA, {DW{1'b0}}}) >>> amt;
  assign rorWide = {opA, opA} >> rot;

  assign overflow    = (opA[DW-1] == bEff[DW-1]) && (sum[DW-1] != opA[DW-1]);
  assign shiftCValid = (amt != 8'd0);

  always_comb begin
    result = sum[DW-1:0];
    carry  = sum[DW];
    case (op)
      ALU_AND: result = opA & opB;
      ALU_EOR: result = opA ^ opB;
      ALU_ORR: result = opA | opB;
      ALU_BIC: result = opA & ~opB;
      ALU_MVN: result = ~opB;
      ALU_LSL: begin result = lslWide[DW-1:0];  carry = lslWide[DW];     end
      ALU_LSR: begin result = lsrWide[2*DW-1:DW]; carry = lsrWide[DW-1]; end
      ALU_ASR: begin result = asrWide[2*DW-1:DW]; carry = asrWide[DW-1]; end
      ALU_ROR: begin result = rorWide[DW-1:0];  carry = rorWide[DW-1];   end
      default: ;
    endcase
  end

endmodule

// File: rtl/m16_branch.sv
module m16_branch (
  input  logic [3:0] cond,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       flagC,
  input  logic       flagV,
  output logic       taken
);

  logic picked;

  always_comb begin
    case (cond[2:1])
      2'b00:   picked = flagZ;
      2'b01:   picked = flagC;
      2'b10:   picked = flagN;
      default: picked = flagV;
    endcase
  end

  assign taken = !cond[3] && (picked ^ cond[0]);

endmodule

// File: rtl/m16_datapath.sv
module m16_datapath
  import m16_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [11:0]   insnLo,
  input  ctrl_t         ctrl,
  input  logic [DW-1:0] dmemRdata,
  output logic [AW-1:0] pcOut,
  output logic [DW-1:0] dmemAddr,
  output logic [DW-1:0] dmemWdata,
  output logic          dmemWe
);

  localparam int RIW = $clog2(NREG);

  logic [RIW-1:0] rdIdx, rnIdx, rmIdx;
  logic [DW-1:0]  regs [NREG];
  logic [DW-1:0]  rdVal, rnVal, rmVal, opA, opB, aluY, wbData;
  logic           aluC, aluV, shiftCValid, brTaken;
  logic           nQ, zQ, cQ, vQ;
  logic [AW-1:0]  pcQ, pcNext, seqPc, condOff, jumpOff;

  assign rdIdx = insnLo[2:0];
  assign rnIdx = insnLo[5:3];
  assign rmIdx = insnLo[8:6];
  assign rdVal = regs[rdIdx];
  assign rnVal = regs[rnIdx];
  assign rmVal = regs[rmIdx];

  assign opA = ctrl.aFromRd ? rdVal : rnVal;

  always_comb begin
    case (ctrl.srcB)
      SRCB_IMM3: opB = {{(DW-3){1'b0}}, insnLo[8:6]};
      SRCB_RN:   opB = rnVal;
      SRCB_OFF5: opB = {{(DW-7){1'b0}}, insnLo[10:6], 2'b00};
      default:   opB = rmVal;
    endcase
  end

  m16_alu #(.DW(DW)) u_alu (
    .opA        (opA),
    .opB        (opB),
    .op         (ctrl.aluOp),
    .result     (aluY),
    .carry      (aluC),
    .overflow   (aluV),
    .shiftCValid(shiftCValid)
  );

  m16_branch u_branch (
    .cond (insnLo[11:8]),
    .flagN(nQ),
    .flagZ(zQ),
    .flagC(cQ),
    .flagV(vQ),
    .taken(brTaken)
  );

  assign wbData = ctrl.memToReg ? dmemRdata : aluY;

  // register file: one write port, one flop bank per register
  for (genvar g = 0; g < NREG; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (ctrl.regWrite && (rdIdx == RIW'(g))) begin
        regs[g] <= wbData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nQ <= 1'b0;
      zQ <= 1'b0;
      cQ <= 1'b0;
      vQ <= 1'b0;
    end else begin
      if (ctrl.setNZ) begin
        nQ <= aluY[DW-1];
        zQ <= (aluY == '0);
      end
      if (ctrl.setCV) begin
        cQ <= aluC;
        vQ <= aluV;
      end else if (ctrl.setShiftC && shiftCValid) begin
        cQ <= aluC;
      end
    end
  end

  assign seqPc   = pcQ + AW'(2);
  assign condOff = {{(AW-9){insnLo[7]}}, insnLo[7:0], 1'b0};
  assign jumpOff = {{(AW-12){insnLo[10]}}, insnLo[10:0], 1'b0};

  always_comb begin
    case (ctrl.npcSel)
      NPC_COND: pcNext = brTaken ? (pcQ + AW'(4) + condOff) : seqPc;
      NPC_JUMP: pcNext = pcQ + AW'(4) + jumpOff;
      default:  pcNext = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= pcNext;
  end

  assign pcOut     = pcQ;
  assign dmemAddr  = aluY;
  assign dmemWdata = rdVal;
  assign dmemWe    = ctrl.memWrite;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pcQ == '0 && {nQ, zQ, cQ, vQ} == 4'b0000)); // R1
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (ctrl.npcSel == NPC_SEQ) |=> (pcQ == $past(pcQ) + AW'(2))); // R2
  AST_STORE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    dmemWe |=> $stable({nQ, zQ, cQ, vQ})); // R3
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (rst)
    (ctrl.setNZ && !ctrl.setCV && !ctrl.setShiftC) |=> $stable({cQ, vQ})); // R5
  AST_ZERO_SHIFT_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
    (ctrl.setShiftC && opB[7:0] == 8'd0) |=> $stable(cQ)); // R6
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.regWrite && !ctrl.memWrite && !ctrl.setNZ && ctrl.npcSel == NPC_SEQ)
      |=> $stable({nQ, zQ, cQ, vQ})); // R7
  AST_PC_HALFWORD: assert property (@(posedge clk) disable iff (rst)
    pcQ[0] == 1'b0); // R8

endmodule

// File: rtl/m16_core.sv
module m16_core
  import m16_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] imemAddr,
  input  logic [15:0]   imemData,
  output logic [DW-1:0] dmemAddr,
  output logic [DW-1:0] dmemWdata,
  output logic          dmemWe,
  input  logic [DW-1:0] dmemRdata
);

  ctrl_t ctrl;

  m16_control u_control (
    .insnHi(imemData[15:6]),
    .ctrl  (ctrl)
  );

  m16_datapath #(.DW(DW), .AW(AW), .NREG(NREG)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .insnLo   (imemData[11:0]),
    .ctrl     (ctrl),
    .dmemRdata(dmemRdata),
    .pcOut    (imemAddr),
    .dmemAddr (dmemAddr),
    .dmemWdata(dmemWdata),
    .dmemWe   (dmemWe)
  );

endmodule

// File: tb/m16_core_bench.sv
module m16_core_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] imemAddr, dmemAddr, dmemWdata, dmemRdata;
  logic [15:0] imemData;
  logic        dmemWe;

  logic [15:0] imem [512];
  logic [31:0] dmem [64];

  assign imemData  = imem[imemAddr[9:1]];
  assign dmemRdata = dmem[dmemAddr[7:2]];
  always @(posedge clk) if (!rst && dmemWe) dmem[dmemAddr[7:2]] <= dmemWdata;

  m16_core u_m16_core (
    .clk      (clk),
    .rst      (rst),
    .imemAddr (imemAddr),
    .imemData (imemData),
    .dmemAddr (dmemAddr),
    .dmemWdata(dmemWdata),
    .dmemWe   (dmemWe),
    .dmemRdata(dmemRdata)
  );

  // reference state
  logic [31:0] mR [8];
  logic [31:0] mMem [64];
  logic [31:0] mPc;
  bit          mN, mZ, mC, mV;
  string       mTag [8];
  string       pcTag;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 0;
  int          wp      = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    end
  endtask

  function automatic logic [15:0] encMem(bit ld, int imm5, int rn, int rd);
    return {4'b0110, ld, 5'(imm5), 3'(rn), 3'(rd)};
  endfunction
  function automatic logic [15:0] encAs(bit imm, bit sub, int rm, int rn, int rd);
    return {5'b00011, imm, sub, 3'(rm), 3'(rn), 3'(rd)};
  endfunction
  function automatic logic [15:0] encDp(int op, int rn, int rd);
    return {6'b010000, 4'(op), 3'(rn), 3'(rd)};
  endfunction
  function automatic logic [15:0] encBc(int cond, int imm8);
    return {4'b1101, 4'(cond), 8'(imm8)};
  endfunction
  function automatic logic [15:0] encB(int imm11);
    return {5'b11100, 11'(imm11)};
  endfunction

  function automatic bit condHolds(logic [3:0] c, bit n, bit z, bit cy, bit v);
    case (c)
      4'd0: return z;
      4'd1: return !z;
      4'd2: return cy;
      4'd3: return !cy;
      4'd4: return n;
      4'd5: return !n;
      4'd6: return v;
      4'd7: return !v;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] randInsn();
    int k;
    k = $urandom_range(99);
    if (k < 18)      return encMem(0, $urandom_range(31), $urandom_range(7), $urandom_range(7));
    else if (k < 32) return encMem(1, $urandom_range(31), $urandom_range(7), $urandom_range(7));
    else if (k < 52) return encAs($urandom_range(1), $urandom_range(1), $urandom_range(7),
                                  $urandom_range(7), $urandom_range(7));
    else if (k < 82) return encDp($urandom_range(15), $urandom_range(7), $urandom_range(7));
    else if (k < 92) return encBc($urandom_range(15), $urandom_range(15));
    else if (k < 95) return encB($urandom_range(15));
    else if (k < 97) return 16'hBF00;
    else             return 16'h0000;
  endfunction

  task automatic put(input logic [15:0] w);
    imem[wp] = w;
    wp++;
  endtask

  // one instruction: check port values for the fetched halfword, then commit
  task automatic step(input logic [15:0] ins);
    logic [2:0]  rd, rn, rm;
    logic [31:0] a, b, r, ea, nextPc;
    logic [32:0] s;
    bit          wr, setNZ, setCV, setC, cy, ov, expWe, usesAddr;
    string       tag;
    int          amt, sh;
    rd = ins[2:0]; rn = ins[5:3]; rm = ins[8:6];
    a = '0; b = '0; r = '0; ea = '0; s = '0;
    wr = 0; setNZ = 0; setCV = 0; setC = 0; cy = 0; ov = 0; expWe = 0; usesAddr = 0;
    tag = "R2"; amt = 0; sh = 0;
    nextPc = mPc + 32'd2;
    if (ins[15:12] == 4'b0110) begin
      tag = "R3"; usesAddr = 1;
      ea = mR[rn] + {25'd0, ins[10:6], 2'b00};
      if (ins[11]) begin r = mMem[ea[7:2]]; wr = 1; end
      else expWe = 1;
    end else if (ins[15:11] == 5'b00011) begin
      tag = "R4"; wr = 1; setNZ = 1; setCV = 1;
      a = mR[rn];
      b = ins[10] ? {29'd0, ins[8:6]} : mR[rm];
      if (ins[9]) s = {1'b0, a} + {1'b0, ~b} + 33'd1;
      else        s = {1'b0, a} + {1'b0, b};
      r = s[31:0]; cy = s[32];
      ov = ins[9] ? (a[31] != b[31] && r[31] != a[31]) : (a[31] == b[31] && r[31] != a[31]);
    end else if (ins[15:10] == 6'b010000) begin
      tag = "R5"; wr = 1; setNZ = 1;
      a = mR[rd]; b = mR[rn]; amt = int'(b[7:0]);
      case (ins[9:6])
        4'b0000: r = a & b;
        4'b0001: r = a ^ b;
        4'b1100: r = a | b;
        4'b1110: r = a & ~b;
        4'b1111: r = ~b;
        4'b0010: begin
          tag = "R6"; setC = (amt != 0);
          if (amt == 0)      r = a;
          else if (amt < 32) begin r = a << amt; cy = a[32-amt]; end
          else if (amt == 32) begin r = '0; cy = a[0]; end
          else begin r = '0; cy = 0; end
        end
        4'b0011: begin
          tag = "R6"; setC = (amt != 0);
          if (amt == 0)      r = a;
          else if (amt < 32) begin r = a >> amt; cy = a[amt-1]; end
          else if (amt == 32) begin r = '0; cy = a[31]; end
          else begin r = '0; cy = 0; end
        end
        4'b0100: begin
          tag = "R6"; setC = (amt != 0);
          if (amt == 0)      r = a;
          else if (amt < 32) begin r = 32'($signed(a) >>> amt); cy = a[amt-1]; end
          else begin r = {32{a[31]}}; cy = a[31]; end
        end
        4'b0111: begin
          tag = "R6"; setC = (amt != 0);
          sh = amt % 32;
          if (sh == 0) r = a;
          else r = (a >> sh) | (a << (32 - sh));
          cy = r[31];
        end
        default: begin tag = "R7"; wr = 0; setNZ = 0; end
      endcase
    end else if (ins[15:12] == 4'b1101) begin
      tag = "R8";
      if (condHolds(ins[11:8], mN, mZ, mC, mV))
        nextPc = mPc + 32'd4 + {{23{ins[7]}}, ins[7:0], 1'b0};
    end else if (ins[15:11] == 5'b11100) begin
      tag = "R9";
      nextPc = mPc + 32'd4 + {{20{ins[10]}}, ins[10:0], 1'b0};
    end else begin
      tag = "R7";
    end

    check(imemAddr === mPc, pcTag, "fetch address", imemAddr, mPc);
    check(dmemWe === expWe, "R3", "store strobe", {31'd0, dmemWe}, {31'd0, expWe});
    if (usesAddr) check(dmemAddr === ea, "R3", "data address", dmemAddr, ea);
    if (expWe) check(dmemWdata === mR[rd], mTag[rd], "store data", dmemWdata, mR[rd]);

    if (wr) begin mR[rd] = r; mTag[rd] = tag; end
    if (setNZ) begin mN = r[31]; mZ = (r == 32'd0); end
    if (setCV) begin mC = cy; mV = ov; end
    if (setC) mC = cy;
    if (expWe) mMem[ea[7:2]] = mR[rd];
    mPc = nextPc;
    pcTag = tag;
  endtask

  initial begin
    void'($urandom(32'd7715));
    for (int i = 0; i < 64; i++)
      dmem[i] = (i % 3 == 0) ? 32'($urandom_range(40)) : $urandom;
    dmem[0] = 32'd32;
    dmem[1] = 32'd33;
    dmem[2] = 32'h8000_0001;
    dmem[3] = 32'h7FFF_FFFF;
    dmem[5] = 32'd1;
    for (int i = 0; i < 64; i++) mMem[i] = dmem[i];

    // directed corner cases first
    put(encBc(0, 5));            // R1/R8: Z clear after reset, not taken
    put(16'h0000);               // R7
    put(16'hBF00);               // R7
    put(encMem(0, 31, 0, 0));    // R1: register zero after reset
    put(encMem(1, 0, 0, 1));     // R3 loads
    put(encMem(1, 1, 0, 2));
    put(encMem(1, 2, 0, 3));
    put(encMem(1, 3, 0, 4));
    put(encMem(1, 5, 0, 5));
    put(encAs(0, 0, 5, 4, 6));   // R4: signed overflow
    put(encBc(6, 0));            // R8: V set, taken, skips the next slot
    put(encMem(0, 31, 0, 1));
    put(encMem(0, 29, 0, 6));
    put(encAs(1, 0, 0, 3, 7));
    put(encDp(4'b0010, 1, 7));   // R6: left shift by 32
    put(encMem(0, 30, 0, 7));
    put(encAs(1, 0, 0, 3, 7));
    put(encDp(4'b0100, 2, 7));   // R6: arithmetic shift by 33
    put(encMem(0, 28, 0, 7));
    put(encAs(1, 0, 0, 3, 7));
    put(encDp(4'b0111, 1, 7));   // R6: rotate by 32
    put(encBc(2, 0));
    put(16'hBF00);
    put(encDp(4'b0011, 0, 7));   // R6: shift by zero keeps C
    put(encBc(2, 0));
    put(16'h0000);
    put(encAs(1, 1, 1, 0, 0));   // R4: 0 - 1 borrows, C clear
    put(encBc(3, 0));
    put(encMem(0, 31, 0, 2));
    put(encDp(4'b0101, 1, 0));   // R7: unlisted op
    put(encMem(0, 27, 1, 0));
    put(encB(1));                // R9
    put(encMem(0, 31, 0, 3));
    put(encMem(0, 31, 0, 4));
    put(encDp(4'b1111, 0, 6));   // R5
    put(encBc(12, 0));           // R8: code 12 never taken
    while (wp < 512) put(randInsn());

    for (int i = 0; i < 8; i++) begin mR[i] = '0; mTag[i] = "R1"; end
    mN = 0; mZ = 0; mC = 0; mV = 0; mPc = '0; pcTag = "R1";

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(imemAddr === 32'd0, "R1", "PC after reset", imemAddr, 32'd0);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      step(imem[mPc[9:1]]);
      @(negedge clk);
    end

    for (int i = 0; i < 64; i++)
      check(dmem[i] === mMem[i], "R3", "final memory word", dmem[i], mMem[i]);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule